// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block takes 32-bit words from a host, queues them in a small transmit FIFO and sends each one on a three-level line. Two outputs represent the line: `line_hi` drives it positive for a one, `line_lo` drives it negative for a zero, and both low means null. Every bit cell has a driven half and a null half. Consecutive words are separated by a null gap four bit cells long. Bit 32 can be replaced by an odd or even parity bit, or the word can be sent raw.

All line timing counts pulses of a 1 MHz reference tick. The tick comes from one of two sources. One is the rising edges of a dedicated reference input. The other is the rising edges of the SPI clock divided by a ratio that the host writes. The host writes a 4-bit control word that selects the tick source, the bit rate, parity enable and parity sense. `tx_ready` is high when no word is queued or in flight. A master reset input ends transmission at once and empties the queue, but keeps the control word and the divide ratio.

Top module: `a429_tx_top`

## Requirements
- R1: After `rst`, `line_hi` and `line_lo` are 0, `fifo_empty` is 1, `fifo_full` is 0 and `tx_ready` is 1.
- R2: Word bits go out in index order: `wr_data[0]` first, `wr_data[31]` last. A one drives only `line_hi`, a zero drives only `line_lo`, and the two are never high together.
- R3: Control bits are mapped as bit0 parity enable, bit1 parity even, bit2 slow rate and bit3 SPI tick source. With bit0=1 and bit1=0, bit 32 is replaced so that the 32 sent bits hold an odd number of ones.
- R4: With bit0=1 and bit1=1, bit 32 is replaced so that the 32 sent bits hold an even number of ones.
- R5: With bit0=0, all 32 written bits are sent unchanged.
- R6: With bit2=0, each bit is 5 ticks driven followed by 5 ticks null. When words follow each other, the last null half and the gap give exactly 45 null ticks.
- R7: With bit2=1, each bit is 40 ticks driven and 40 ticks null, and the null run between back-to-back words is exactly 360 ticks.
- R8: With bit3=0, `ref_tick` pulses once per rising edge of `ext_ref`. With bit3=1 and a ratio N of 2 or more, it pulses once per N rising edges of `spi_sck`. A ratio of 0 or 1 gives one pulse per edge. Each pulse lasts a single `clk` cycle.
- R9: The FIFO holds 8 words and raises `fifo_full` while 8 are held. A write while full is ignored and the word is never sent.
- R10: An accepted write makes `tx_ready` low on the next cycle. `tx_ready` returns high, with the line null, once the FIFO is empty and the last word's final bit cell has ended.
- R11: A `mr` pulse makes the line null, `fifo_empty` 1 and `tx_ready` 1 on the next cycle. Queued words are dropped, and the control word and divide ratio are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| mr | input | 1 | Master reset: clears the FIFO and stops the current word |
| ext_ref | input | 1 | Dedicated reference clock level |
| spi_sck | input | 1 | SPI clock level, used as the divided tick source |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word (bit map in R3) |
| div_we | input | 1 | Divide ratio write strobe |
| div_wdata | input | 8 | Divide ratio for the SPI clock source |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | Word to send |
| fifo_full | output | 1 | FIFO holds 8 words |
| fifo_empty | output | 1 | FIFO holds no word |
| tx_ready | output | 1 | No word queued or being sent |
| ref_tick | output | 1 | Single-cycle 1 MHz reference pulse |
| line_hi | output | 1 | Drive line positive |
| line_lo | output | 1 | Drive line negative |

## Verification
A monitor on the line turns the output into one symbol per reference tick. It measures every driven and null run and rebuilds each word, so any of these faults shows up as a wrong word or a wrong run length: bit order reversed, parity sense swapped, parity not bypassed, a half-cell off by one tick, or a gap that adds the extra idle tick before the next word. A stopped SPI clock freezes transmission so the FIFO can be filled to the brim. A ninth write that overwrote a stored word would then appear in the output. The tick period is measured for the reference source, for ratios 0 and 1, and for a larger ratio. A divider that counted one edge too many or too few changes that period. A master reset issued in the middle of a word must leave the line null, the queue empty and the parity setting intact.

// File: rtl/a429_pkg.sv
package a429_pkg;

    localparam int WORD_W    = 32;
    localparam int HALF_FAST = 5;
    localparam int HALF_SLOW = 40;
    localparam int GAP_BITS  = 4;
    localparam int CNT_W     = $clog2(2 * GAP_BITS * HALF_SLOW + 1);
    localparam int IDX_W     = $clog2(WORD_W);

    // Control word: bit3 src_spi, bit2 slow, bit1 par_even, bit0 par_en
    typedef struct packed {
        logic src_spi;
        logic slow;
        logic par_even;
        logic par_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DRIVE,
        TX_NULL,
        TX_GAP
    } tx_state_e;

    function automatic logic [WORD_W-1:0] apply_parity(input logic [WORD_W-1:0] w,
                                                       input ctrl_t c);
        logic [WORD_W-1:0] r;
        r = w;
        if (c.par_en)
            r[WORD_W-1] = (^w[WORD_W-2:0]) ^ ~c.par_even;
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] half_ticks(input logic slow);
        return slow ? CNT_W'(HALF_SLOW) : CNT_W'(HALF_FAST);
    endfunction

endpackage

// File: rtl/a429_tick_gen.sv
module a429_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_spi,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             ext_ref,
    input  logic             spi_sck,
    output logic             tick
);
    logic             sel_raw;
    logic [2:0]       sync_q;
    logic             rise;
    logic [DIV_W-1:0] div_cnt;

    assign sel_raw = src_spi ? spi_sck : ext_ref;
    assign rise    = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], sel_raw};
            tick   <= 1'b0;
            if (rise) begin
                if (!src_spi || div_ratio <= DIV_W'(1)) begin
                    tick    <= 1'b1;
                    div_cnt <= '0;
                end else if (div_cnt >= div_ratio - DIV_W'(1)) begin
                    tick    <= 1'b1;
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
        end
    end

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R8

endmodule

// File: rtl/a429_fifo.sv
module a429_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp, used;
    logic          do_push, do_pop;

    assign used    = wp - rp;
    assign full    = (used == PW'(DEPTH));
    assign empty   = (used == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + PW'(1);
            if (do_pop)  rp <= rp + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr)
            mem[wp[AW-1:0]] <= wdata;
    end

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (full && $stable(wp))); // R9

endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
    import a429_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  ctrl_t             ctrl,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              pop,
    output logic              busy,
    output logic              line_hi,
    output logic              line_lo
);
    tx_state_e         state;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  half, gap;
    logic              cur_bit;

    assign half    = half_ticks(ctrl.slow);
    assign gap     = half * CNT_W'(2 * GAP_BITS);
    assign cur_bit = word_q[idx];
    assign busy    = (state == TX_DRIVE) || (state == TX_NULL);
    assign line_hi = (state == TX_DRIVE) &&  cur_bit;
    assign line_lo = (state == TX_DRIVE) && !cur_bit;

    always_comb begin
        pop = 1'b0;
        if (tick && !fifo_empty) begin
            if (state == TX_IDLE)
                pop = 1'b1;
            else if (state == TX_GAP && cnt >= gap - CNT_W'(1))
                pop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state  <= TX_IDLE;
            word_q <= '0;
            idx    <= '0;
            cnt    <= '0;
        end else if (tick) begin
            if (pop) begin
                word_q <= apply_parity(fifo_rdata, ctrl);
                idx    <= '0;
                cnt    <= '0;
                state  <= TX_DRIVE;
            end else begin
                case (state)
                    TX_IDLE: cnt <= '0;
                    TX_DRIVE: begin
                        if (cnt >= half - CNT_W'(1)) begin
                            cnt   <= '0;
                            state <= TX_NULL;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    TX_NULL: begin
                        if (cnt >= half - CNT_W'(1)) begin
                            cnt <= '0;
                            if (idx == IDX_W'(WORD_W - 1)) begin
                                state <= TX_GAP;
                            end else begin
                                idx   <= idx + IDX_W'(1);
                                state <= TX_DRIVE;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: begin
                        if (cnt >= gap - CNT_W'(1)) begin
                            cnt   <= '0;
                            state <= TX_IDLE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr && ctrl.par_en && !ctrl.par_even) |=> (^word_q)); // R3

    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr && ctrl.par_en && ctrl.par_even) |=> !(^word_q)); // R4

    AST_PARITY_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr && !ctrl.par_en) |=> (word_q == $past(fifo_rdata))); // R5

    AST_MR_NULL: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!line_hi && !line_lo)); // R11

endmodule

// File: rtl/a429_tx_top.sv
module a429_tx_top
    import a429_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mr,
    input  logic              ext_ref,
    input  logic              spi_sck,
    input  logic              ctrl_we,
    input  logic [3:0]        ctrl_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              tx_ready,
    output logic              ref_tick,
    output logic              line_hi,
    output logic              line_lo
);
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic              pop, busy;
    logic [WORD_W-1:0] head;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
            if (div_we)  div_q  <= div_wdata;
        end
    end

    a429_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .src_spi  (ctrl_q.src_spi),
        .div_ratio(div_q),
        .ext_ref  (ext_ref),
        .spi_sck  (spi_sck),
        .tick     (ref_tick)
    );

    a429_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .clr  (mr),
        .push (wr_en),
        .wdata(wr_data),
        .pop  (pop),
        .rdata(head),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    a429_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .clr       (mr),
        .tick      (ref_tick),
        .ctrl      (ctrl_q),
        .fifo_empty(fifo_empty),
        .fifo_rdata(head),
        .pop       (pop),
        .busy      (busy),
        .line_hi   (line_hi),
        .line_lo   (line_lo)
    );

    assign tx_ready = fifo_empty && !busy;

    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !fifo_full && !mr) |=> !tx_ready); // R10

    AST_MR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        mr |=> (fifo_empty && tx_ready)); // R11

endmodule

// File: tb/tb_a429_tx_top.sv
module tb_a429_tx_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mr = 1'b0;
    logic        ext_ref = 1'b0;
    logic        spi_sck = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [3:0]  ctrl_wdata = '0;
    logic        div_we = 1'b0;
    logic [7:0]  div_wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        fifo_full, fifo_empty, tx_ready, ref_tick, line_hi, line_lo;

    a429_tx_top dut (
        .clk(clk), .rst(rst), .mr(mr), .ext_ref(ext_ref), .spi_sck(spi_sck),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .div_we(div_we),
        .div_wdata(div_wdata), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .tx_ready(tx_ready),
        .ref_tick(ref_tick), .line_hi(line_hi), .line_lo(line_lo)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // reference sources driven away from the active edge
    int ext_div = 0;
    always @(negedge clk) begin
        ext_div++;
        if (ext_div == 4) begin ext_div = 0; ext_ref = ~ext_ref; end
    end
    logic sck_run = 1'b0;
    int   sck_div = 0;
    always @(negedge clk) begin
        if (sck_run) begin
            sck_div++;
            if (sck_div == 2) begin sck_div = 0; spi_sck = ~spi_sck; end
        end
    end

    // line monitor: one symbol per tick (0 null, 1 high, 2 low)
    int          half_exp = 5;
    int          gap_exp  = 40;
    logic [31:0] rx [16];
    int          rx_n = 0, nbits = 0, run = 0, prev_sym = 0;
    int          tim_err = 0, gap_bad = 0, ovl_err = 0;
    bit          after_word = 0;
    logic [31:0] cur = '0;

    task automatic dec_clear();
        rx_n = 0; nbits = 0; run = 0; prev_sym = 0;
        tim_err = 0; gap_bad = 0; ovl_err = 0; after_word = 0; cur = '0;
    endtask

    task automatic end_run();
        if (prev_sym != 0) begin
            if (run != half_exp) tim_err++;
            if (nbits < 32) begin
                cur[nbits] = (prev_sym == 1);
                nbits++;
            end else tim_err++;
        end else begin
            if (nbits == 32) begin
                tim_err++;
                nbits = 0;
            end else if (nbits > 0) begin
                if (run != half_exp) tim_err++;
            end else if (after_word) begin
                if (run != half_exp + gap_exp) gap_bad++;
                after_word = 0;
            end
        end
    endtask

    always @(negedge clk) begin
        int sym;
        if (line_hi && line_lo) ovl_err++;
        if (ref_tick) begin
            sym = line_hi ? 1 : (line_lo ? 2 : 0);
            if (sym == prev_sym) run++;
            else begin
                end_run();
                prev_sym = sym;
                run = 1;
            end
            if (sym == 0 && nbits == 32 && run == half_exp + gap_exp) begin
                if (rx_n < 16) rx[rx_n] = cur;
                rx_n++;
                nbits = 0;
                after_word = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] w, input bit en,
                                             input bit even);
        logic [31:0] r;
        int ones;
        r = w;
        if (en) begin
            ones = $countones(w[30:0]);
            r[31] = even ? (ones % 2 == 1) : (ones % 2 == 0);
        end
        return r;
    endfunction

    task automatic set_ctrl(input logic [3:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] v);
        @(negedge clk); div_we = 1'b1; div_wdata = v;
        @(negedge clk); div_we = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        int k;
        k = 0;
        while (k < n) begin
            @(negedge clk);
            if (ref_tick) k++;
        end
    endtask

    task automatic wait_done(input string req);
        while (!tx_ready) @(negedge clk);
        chk(!line_hi && !line_lo && fifo_empty, req, "null line at ready",
            {30'b0, line_hi, line_lo}, 32'h0);
        wait_ticks(half_exp + gap_exp + 4);
    endtask

    task automatic tick_period(output int n);
        while (!ref_tick) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_tick);
    endtask

    logic [31:0] words [9];
    int          per;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!line_hi && !line_lo, "R1", "line null", {30'b0, line_hi, line_lo}, 0);
        chk(fifo_empty && !fifo_full, "R1", "fifo flags", {30'b0, fifo_empty, fifo_full}, 32'h2);
        chk(tx_ready, "R1", "tx_ready", {31'b0, tx_ready}, 1);

        // R8 tick source and divider
        repeat (20) @(negedge clk);
        tick_period(per); tick_period(per);
        chk(per == 8, "R8", "ext tick period", per, 8);
        sck_run = 1'b1;
        set_div(8'd0); set_ctrl(4'b1000);
        tick_period(per); tick_period(per);
        chk(per == 4, "R8", "ratio 0 period", per, 4);
        set_div(8'd3);
        tick_period(per); tick_period(per); tick_period(per);
        chk(per == 12, "R8", "ratio 3 period", per, 12);
        set_div(8'd1);
        tick_period(per); tick_period(per);
        chk(per == 4, "R8", "ratio 1 period", per, 4);

        // R3 odd parity, fast rate, external source, back-to-back
        set_ctrl(4'b0001);
        half_exp = 5; gap_exp = 40;
        wait_ticks(60);
        dec_clear();
        words[0] = 32'h0000_0001; words[1] = 32'h7FFF_FFFF; words[2] = 32'h1234_5678;
        push(words[0]);
        chk(!tx_ready, "R10", "ready low after write", {31'b0, tx_ready}, 0);
        push(words[1]); push(words[2]);
        wait_done("R10");
        chk(rx_n == 3, "R2", "word count odd", rx_n, 3);
        for (int i = 0; i < 3; i++)
            chk(rx[i] == exp_word(words[i], 1, 0), "R3", "odd parity word", rx[i],
                exp_word(words[i], 1, 0));
        chk(tim_err == 0, "R6", "fast cell timing", tim_err, 0);
        chk(gap_bad == 0, "R6", "fast word gap", gap_bad, 0);
        chk(ovl_err == 0, "R2", "no double drive", ovl_err, 0);

        // R4 even parity, SPI source ratio 1
        set_ctrl(4'b1011);
        wait_ticks(60);
        dec_clear();
        words[0] = 32'h0000_0003; words[1] = 32'hC0DE_F00D;
        push(words[0]); push(words[1]);
        wait_done("R10");
        chk(rx_n == 2, "R4", "word count even", rx_n, 2);
        for (int i = 0; i < 2; i++)
            chk(rx[i] == exp_word(words[i], 1, 1), "R4", "even parity word", rx[i],
                exp_word(words[i], 1, 1));

        // R5 parity bypass, bit order R2
        set_ctrl(4'b1000);
        dec_clear();
        words[0] = 32'h8000_0000; words[1] = 32'hA5C3_0F1E; words[2] = 32'h0000_0001;
        push(words[0]); push(words[1]); push(words[2]);
        wait_done("R10");
        chk(rx_n == 3, "R5", "word count raw", rx_n, 3);
        for (int i = 0; i < 3; i++)
            chk(rx[i] == words[i], "R5", "raw word", rx[i], words[i]);
        chk(tim_err == 0 && gap_bad == 0, "R6", "raw timing", tim_err + gap_bad, 0);

        // R9 fill with stopped clock, overflow write ignored
        sck_run = 1'b0;
        repeat (10) @(negedge clk);
        dec_clear();
        for (int i = 0; i < 9; i++) words[i] = (32'h1357_9BDF * (i + 1)) ^ (32'h0F0F_0000 >> i);
        for (int i = 0; i < 8; i++) push(words[i]);
        chk(fifo_full, "R9", "full after 8", {31'b0, fifo_full}, 1);
        push(words[8]);
        chk(fifo_full, "R9", "still full", {31'b0, fifo_full}, 1);
        sck_run = 1'b1;
        wait_done("R10");
        chk(rx_n == 8, "R9", "only 8 words sent", rx_n, 8);
        for (int i = 0; i < 8; i++)
            chk(rx[i] == words[i], "R9", "stored word", rx[i], words[i]);
        chk(tim_err == 0 && gap_bad == 0, "R6", "burst timing", tim_err + gap_bad, 0);

        // R11 master reset mid-word keeps control
        set_ctrl(4'b1011);
        push(32'h1111_2222); push(32'h3333_4444); push(32'h5555_6666);
        wait_ticks(47);
        @(negedge clk); mr = 1'b1;
        @(negedge clk); mr = 1'b0;
        chk(!line_hi && !line_lo, "R11", "line null after mr", {30'b0, line_hi, line_lo}, 0);
        chk(fifo_empty && tx_ready, "R11", "queue cleared", {30'b0, fifo_empty, tx_ready}, 32'h3);
        dec_clear();
        wait_ticks(60);
        chk(rx_n == 0 && !line_hi && !line_lo, "R11", "nothing sent after mr", rx_n, 0);
        push(32'h0F00_0001);
        wait_done("R11");
        chk(rx_n == 1, "R11", "one word after mr", rx_n, 1);
        chk(rx[0] == exp_word(32'h0F00_0001, 1, 1), "R11", "control kept", rx[0],
            exp_word(32'h0F00_0001, 1, 1));

        // R7 slow rate
        set_ctrl(4'b1101);
        half_exp = 40; gap_exp = 320;
        wait_ticks(400);
        dec_clear();
        words[0] = 32'h00FF_0F0A; words[1] = 32'h4000_0000;
        push(words[0]); push(words[1]);
        wait_done("R10");
        chk(rx_n == 2, "R7", "slow word count", rx_n, 2);
        for (int i = 0; i < 2; i++)
            chk(rx[i] == exp_word(words[i], 1, 0), "R7", "slow word", rx[i],
                exp_word(words[i], 1, 0));
        chk(tim_err == 0, "R7", "slow cell timing", tim_err, 0);
        chk(gap_bad == 0, "R7", "slow word gap", gap_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule